// File: doc/BRIEF.md
# Single-Bit Asynchronous SRAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM holding 65,536 one-bit words, with separate data-in and data-out pins and active-low chip-select and write-strobe pins. The host issues one request at a time through a valid/ready handshake. Each request carries a 16-bit address, a direction bit and, for writes, one data bit.

The sequencer drives the memory pins from a single state machine. A loadable down-counter paces the states. Every memory timing limit is a nanosecond parameter, and the block converts it to whole clock cycles by rounding up against a clock-period parameter. Each access starts with a setup cycle that drives the address while chip select is still high. During a write, chip select and the write strobe fall together, and the write strobe always rises first to close the write. Data-in stays unchanged for one more cycle after that rise. On a read, the captured bit comes back with a one-cycle response strobe. Between requests, chip select is high, so the memory sits in its low-power deselected state.

Top module: `sram_x1_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it: `mem_ce_no`=1, `mem_we_no`=1, `mem_din_o`=0, `req_ready_o`=1, `rsp_valid_o`=0.
- R2: Whenever `req_ready_o` is high, `mem_ce_no` and `mem_we_no` are both high, so the memory is deselected between requests.
- R3: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. After that, `req_ready_o` stays low for 1+ceil(max(tAA,tRC)/Tclk) cycles for a read (8 with defaults). For a write it stays low for 1+P+Q cycles, where P=ceil(max(tPWE,tSCE,tSD)/Tclk) and Q=max(1, ceil(tWC/Tclk)-P-1) (7 with defaults).
- R4: `mem_addr_o` never changes while `mem_ce_no` is low. The address is valid from before chip select falls until after it rises.
- R5: During a read, `mem_we_no` stays high. The data-out pin is sampled no sooner than tAA after chip select falls, and the returned bit is the one most recently written to that address (0 if never written).
- R6: Every read produces exactly one `rsp_valid_o` pulse, one cycle wide. Writes produce none.
- R7: During a write, `mem_ce_no` and `mem_we_no` are both low for at least max(tPWE,tSCE). `mem_we_no` rises at least one cycle before `mem_ce_no` rises.
- R8: `mem_din_o` is stable for at least tSD before `mem_we_no` rises and for one cycle afterwards.
- R9: `mem_we_no` is never low while `mem_ce_no` is high.
- R10: Addresses 0x0000 and 0xFFFF are written and read back like any other address, and a later write to an address replaces the earlier bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Sequencer can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Word address |
| req_wdata_i | input | 1 | Write data bit |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_rdata_o | output | 1 | Read data bit |
| mem_addr_o | output | 16 | Memory address pins |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_din_o | output | 1 | Memory data-in pin |
| mem_dout_i | input | 1 | Memory data-out pin |

## Verification
The bench models the memory in nanoseconds. Its data-out pin shows the inverted bit until tAA has passed since chip select fell and the address last changed. A sequencer that samples one cycle early therefore returns wrong read data, and so does one that counts down from the wrong load value. The memory model times each write pulse and data-setup window from the actual pin edges, so a pulse that is one cycle short shows up directly. It also flags any change of address or data-in that falls inside the write window. Back-to-back writes and reads at 0x0000 and 0xFFFF, and repeated writes to one address, catch lost or stale commits. The bench also counts the busy cycles of every request against the derived cycle counts.

// File: rtl/sram_x1_pkg.sv
`timescale 1ns/1ps
package sram_x1_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_SETUP, ST_RD_WAIT, ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_x1_timer.sv
`timescale 1ns/1ps
module sram_x1_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R3
  timer_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_x1_rdcap.sv
`timescale 1ns/1ps
module sram_x1_rdcap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic dout_i,
  output logic rsp_valid_o,
  output logic rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= 1'b0;
    end else begin
      rsp_valid_o <= cap_i;
      if (cap_i) rsp_rdata_o <= dout_i;
    end
  end

  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/sram_x1_ctrl.sv
`timescale 1ns/1ps
module sram_x1_ctrl
  import sram_x1_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CLK_NS    = 4,
  parameter int unsigned T_AA_NS   = 25,
  parameter int unsigned T_RC_NS   = 25,
  parameter int unsigned T_PWE_NS  = 15,
  parameter int unsigned T_SCE_NS  = 20,
  parameter int unsigned T_SD_NS   = 10,
  parameter int unsigned T_WC_NS   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_din_o,
  input  logic              mem_dout_i
);
  localparam int unsigned RD_CYC_RAW = ns_to_cyc(max2(T_AA_NS, T_RC_NS), CLK_NS);
  localparam int unsigned RD_CYC     = max2(RD_CYC_RAW, 1);
  localparam int unsigned PW_CYC_RAW = ns_to_cyc(max2(max2(T_PWE_NS, T_SCE_NS), T_SD_NS), CLK_NS);
  localparam int unsigned PW_CYC     = max2(PW_CYC_RAW, 1);
  localparam int unsigned WC_CYC     = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned REC_CYC    = (WC_CYC > PW_CYC + 2) ? WC_CYC - PW_CYC - 1 : 1;
  localparam int unsigned MAX_CYC    = max2(max2(RD_CYC, PW_CYC), REC_CYC);
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  seq_state_e        st_q, st_d;
  logic              tmr_load, tmr_done, cap;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d    = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    unique case (st_q)
      ST_IDLE:     if (req_valid_i) st_d = req_write_i ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP: begin
        st_d = ST_RD_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RD_CYC - 1);
      end
      ST_RD_WAIT:  if (tmr_done) begin
        st_d = ST_IDLE;
        cap  = 1'b1;
      end
      ST_WR_SETUP: begin
        st_d = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PW_CYC - 1);
      end
      ST_WR_PULSE: if (tmr_done) begin
        st_d = ST_WR_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_CYC - 1);
      end
      ST_WR_RECOVER: if (tmr_done) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  // pins are registered from the next state so they never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mem_addr_o <= '0;
      mem_din_o  <= 1'b0;
      mem_ce_no  <= 1'b1;
      mem_we_no  <= 1'b1;
    end else begin
      st_q      <= st_d;
      mem_ce_no <= !(st_d inside {ST_RD_WAIT, ST_WR_PULSE, ST_WR_RECOVER});
      mem_we_no <= (st_d != ST_WR_PULSE);
      if (accept) begin
        mem_addr_o <= req_addr_i;
        if (req_write_i) mem_din_o <= req_wdata_i;
      end
    end
  end

  sram_x1_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_x1_rdcap u_rdcap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .dout_i      (mem_dout_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  // R9
  we_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no);
  // R2
  idle_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && mem_we_no));
  // R4
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !$past(mem_ce_no)) |-> $stable(mem_addr_o));
  // R8
  din_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |=> $stable(mem_din_o));
  // R7
  we_ends_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> $past(mem_we_no));
  // R5
  rd_we_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD_WAIT) |-> mem_we_no);
endmodule

// File: tb/sram_x1_ctrl_tb.sv
`timescale 1ns/1ps
module sram_x1_ctrl_tb;
  localparam int CLK_NS = 4;
  localparam real T_AA = 25.0, T_PWE = 15.0, T_SCE = 20.0, T_SD = 10.0, T_LZ = 5.0;
  // R3: read busy = 1 + ceil(25/4); write busy = 1 + ceil(20/4) + max(1, 5-5-1)
  localparam int EXP_RD_BUSY = 1 + (25 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WR_BUSY = 1 + (20 + CLK_NS - 1) / CLK_NS + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata;
  logic [15:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_din;
  logic mem_dout = 1'b0;

  int checks = 0, errors = 0, n_rsp = 0, n_rd = 0;
  bit ref_mem [int];
  bit sram [int];
  bit exp_q [$];

  always #2 clk = ~clk;

  sram_x1_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n),
    .mem_din_o(mem_din), .mem_dout_i(mem_dout)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit rd_arr(ref bit arr [int], input int a);
    return arr.exists(a) ? arr[a] : 1'b0;
  endfunction

  // ---------------- memory model ----------------
  realtime t_ce_fall = 0, t_we_fall = 0, t_we_rise = 0, t_addr = 0, t_din = 0;

  always @(negedge mem_ce_n) t_ce_fall = $realtime;
  always @(mem_addr) begin
    t_addr = $realtime;
    if (rst_n && !mem_ce_n) chk(1'b0, "R4 addr change while selected", 1, 0);
  end
  always @(mem_din) begin
    t_din = $realtime;
    if (rst_n && !mem_ce_n && (!mem_we_n || t_we_rise == $realtime))
      chk(1'b0, "R8 din change inside write window", 1, 0);
  end
  always @(negedge mem_we_n) begin
    t_we_fall = $realtime;
    if (mem_ce_n) chk(1'b0, "R9 write strobe without select", 1, 0);
  end
  always @(posedge mem_we_n) begin
    t_we_rise = $realtime;
    if (rst_n && !mem_ce_n) begin
      chk(($realtime - t_we_fall) >= T_PWE, "R7 strobe width ns", int'($realtime - t_we_fall), int'(T_PWE));
      chk(($realtime - t_ce_fall) >= T_SCE, "R7 select to end ns", int'($realtime - t_ce_fall), int'(T_SCE));
      chk(($realtime - t_din) >= T_SD, "R8 din setup ns", int'($realtime - t_din), int'(T_SD));
      sram[int'(mem_addr)] = mem_din;
    end
  end
  always @(posedge mem_ce_n)
    if (rst_n && !mem_we_n) chk(1'b0, "R7 select ended write", 0, 1);

  initial begin
    #0.5;
    forever begin
      if (!mem_ce_n && mem_we_n && ($realtime - t_ce_fall) >= T_AA &&
          ($realtime - t_addr) >= T_AA && ($realtime - t_we_rise) >= T_LZ)
        mem_dout = rd_arr(sram, int'(mem_addr));
      else
        mem_dout = ~rd_arr(sram, int'(mem_addr));
      #1;
    end
  end

  // ---------------- monitor ----------------
  bit rsp_prev = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      n_rsp++;
      if (rsp_prev) chk(1'b0, "R6 response wider than one cycle", 2, 1);
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected response", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R5 read data", rsp_rdata, e);
      end
    end
    if (req_ready) chk(mem_ce_n && mem_we_n, "R2 deselected when ready", {mem_ce_n, mem_we_n}, 3);
    rsp_prev = rsp_valid;
  end

  // ---------------- driver ----------------
  task automatic do_req(bit wr, logic [15:0] a, bit d);
    int busy;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) ref_mem[int'(a)] = d;
    else begin
      exp_q.push_back(rd_arr(ref_mem, int'(a)));
      n_rd++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin
      busy++;
      @(negedge clk);
    end
    if (wr) chk(busy == EXP_WR_BUSY, "R3 write busy cycles", busy, EXP_WR_BUSY);
    else    chk(busy == EXP_RD_BUSY, "R3 read busy cycles", busy, EXP_RD_BUSY);
  endtask

  initial begin
    #(200000 * CLK_NS);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    // R1
    chk(mem_ce_n && mem_we_n && !mem_din && req_ready && !rsp_valid, "R1 reset state",
        {mem_ce_n, mem_we_n, mem_din, req_ready, rsp_valid}, 5'b11010);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && !mem_din && req_ready && !rsp_valid, "R1 after reset",
        {mem_ce_n, mem_we_n, mem_din, req_ready, rsp_valid}, 5'b11010);

    do_req(1'b0, 16'h1234, 1'b0);            // R5 unwritten address reads 0
    do_req(1'b1, 16'h0000, 1'b1);            // R10 low boundary
    do_req(1'b1, 16'hFFFF, 1'b1);            // R10 high boundary
    do_req(1'b0, 16'h0000, 1'b0);
    do_req(1'b0, 16'hFFFF, 1'b0);
    do_req(1'b1, 16'hFFFF, 1'b0);            // R10 overwrite
    do_req(1'b0, 16'hFFFF, 1'b0);
    for (int i = 0; i < 24; i++)
      do_req(1'b1, 16'(i * 16'h0A5B + 3), 1'((i ^ (i >> 2)) & 1));
    for (int i = 23; i >= 0; i--)
      do_req(1'b0, 16'(i * 16'h0A5B + 3), 1'b0);
    for (int i = 0; i < 8; i++) begin        // alternating write/read same address
      do_req(1'b1, 16'h00F0 + 16'(i), 1'(~i & 1));
      do_req(1'b0, 16'h00F0 + 16'(i), 1'b0);
    end
    repeat (4) @(negedge clk);
    // R6
    chk(n_rsp == n_rd, "R6 one response per read", n_rsp, n_rd);
    chk(exp_q.size() == 0, "R6 no pending responses", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule